// File: doc/BRIEF.md
# Floating-Point Min/Max and Quiet Compare Unit

This block takes two IEEE-754 operands and, in one clock, returns either the smaller or larger of them, or a one-bit answer to an equal, greater-than or greater-or-equal question. A precision input selects 32-bit single or 64-bit double format. In single precision only the low 32 bits of each operand are read, and the upper half of the result is zero.

NaN handling is deliberately non-standard. A NaN here is any value whose exponent is all ones and whose mantissa is non-zero. Min and max skip a lone NaN and return the other operand. Two NaNs produce an all-ones pattern rather than a standard quiet NaN. Whether the invalid flag is raised depends only on precision. The compares never raise a flag.

The flag output is a per-operation pulse that a surrounding status register would accumulate. That register is not part of this block.

Top module: `fpmm_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the result, predicate and flags are all zero.
- R2: Every output is registered. The result for inputs presented before a rising edge appears after that edge. Op code 0 is min and op code 1 is max. Ordered operands are compared by sign and magnitude, including negatives and infinities. In single precision the upper 32 result bits are zero and the upper 32 operand bits are ignored.
- R3: For min or max with exactly one NaN operand, the result is the other operand.
- R4: For min or max with exactly one NaN, single precision raises no flag and double precision raises invalid (flag bit 1).
- R5: For min or max with both operands NaN, the result is all ones across the selected width: 0x00000000FFFFFFFF in single precision and all 64 bits in double.
- R6: For min or max with both operands NaN, single precision raises no flag and double precision raises invalid (flag bit 1).
- R7: When +0 and -0 meet, min returns -0 and max returns +0, whatever the operand order.
- R8: Op code 2 is equal, 3 is a greater-than b and 4 is a greater-or-equal b. The answer appears on the predicate output, +0 and -0 compare equal, and the result bus is zero.
- R9: A compare with any NaN operand returns false and raises no flag, in both precisions.
- R10: Flags form a pulse for the current operation only. Bit 0 and bits above 5 are always zero, and an operation without NaN that follows a flagged one shows no flags.
- R11: Op codes 5 to 7 give a zero result, a zero predicate and no flags, even with NaN operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_a_i | input | 64 | Operand a (low 32 bits in single precision) |
| op_b_i | input | 64 | Operand b (low 32 bits in single precision) |
| op_i | input | 3 | Operation: 0 min, 1 max, 2 eq, 3 gt, 4 ge |
| dbl_i | input | 1 | 1 selects double precision, 0 single |
| res_o | output | 64 | Registered min/max result |
| pred_o | output | 1 | Registered compare predicate |
| flags_o | output | 8 | Registered exception flags, invalid at bit 1 |

## Verification
Min and max are driven with positive pairs, mixed-sign pairs and pairs of negatives. This shows whether the order flips with the sign. Infinity and a NaN with only the lowest mantissa bit set show whether the exponent and mantissa tests are correct. Single-precision operands carry junk in their upper halves, which exposes any read of the wrong bits. Each NaN case is run in both precisions and with the NaN on each side, so the flag policy and the pick of the surviving operand are checked separately. Signed zeros are tried in both orders. A flagged operation followed by a clean one shows whether the flags are held over.

// File: rtl/fpmm_pkg.sv
package fpmm_pkg;
    typedef enum logic [2:0] {
        FMM_MIN = 3'd0,
        FMM_MAX = 3'd1,
        FMM_EQ  = 3'd2,
        FMM_GT  = 3'd3,
        FMM_GE  = 3'd4
    } fmm_op_e;

    localparam int FLG_INVALID = 1;
endpackage

// File: rtl/fpmm_class.sv
module fpmm_class #(
    parameter int SP_EXP = 8,
    parameter int SP_MAN = 23,
    parameter int DP_EXP = 11,
    parameter int DP_MAN = 52,
    localparam int SP_W  = 1 + SP_EXP + SP_MAN,
    localparam int DP_W  = 1 + DP_EXP + DP_MAN,
    localparam int MAG_W = DP_W - 1
) (
    input  logic [DP_W-1:0]  val_i,
    input  logic             dbl_i,
    output logic             nan_o,
    output logic             zero_o,
    output logic             sign_o,
    output logic [MAG_W-1:0] mag_o
);
    logic [SP_EXP-1:0] sp_exp;
    logic [DP_EXP-1:0] dp_exp;
    logic              sp_nan, dp_nan;

    assign sp_exp = val_i[SP_W-2 -: SP_EXP];
    assign dp_exp = val_i[DP_W-2 -: DP_EXP];
    assign sp_nan = (&sp_exp) && (|val_i[SP_MAN-1:0]);
    assign dp_nan = (&dp_exp) && (|val_i[DP_MAN-1:0]);

    always_comb begin
        if (dbl_i) begin
            nan_o  = dp_nan;
            sign_o = val_i[DP_W-1];
            mag_o  = val_i[MAG_W-1:0];
        end else begin
            nan_o  = sp_nan;
            sign_o = val_i[SP_W-1];
            mag_o  = {{(MAG_W-SP_W+1){1'b0}}, val_i[SP_W-2:0]};
        end
        zero_o = (mag_o == '0);
    end
endmodule

// File: rtl/fpmm_order.sv
module fpmm_order #(
    parameter int MAG_W = 63
) (
    input  logic             sa_i,
    input  logic             sb_i,
    input  logic             za_i,
    input  logic             zb_i,
    input  logic [MAG_W-1:0] ma_i,
    input  logic [MAG_W-1:0] mb_i,
    output logic             lt_o,
    output logic             eq_o,
    output logic             gt_o
);
    logic mag_gt, mag_lt;

    assign mag_gt = ma_i > mb_i;
    assign mag_lt = ma_i < mb_i;

    always_comb begin
        lt_o = 1'b0;
        gt_o = 1'b0;
        eq_o = 1'b0;
        if (za_i && zb_i) begin
            eq_o = 1'b1;
        end else if (sa_i != sb_i) begin
            gt_o = !sa_i;
            lt_o = sa_i;
        end else if (!sa_i) begin
            gt_o = mag_gt;
            lt_o = mag_lt;
            eq_o = !mag_gt && !mag_lt;
        end else begin
            gt_o = mag_lt;
            lt_o = mag_gt;
            eq_o = !mag_gt && !mag_lt;
        end
    end
endmodule

// File: rtl/fpmm_unit.sv
module fpmm_unit
    import fpmm_pkg::*;
#(
    parameter int SP_EXP = 8,
    parameter int SP_MAN = 23,
    parameter int DP_EXP = 11,
    parameter int DP_MAN = 52,
    parameter int FLAG_W = 8,
    localparam int SP_W  = 1 + SP_EXP + SP_MAN,
    localparam int DP_W  = 1 + DP_EXP + DP_MAN,
    localparam int MAG_W = DP_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DP_W-1:0]   op_a_i,
    input  logic [DP_W-1:0]   op_b_i,
    input  logic [2:0]        op_i,
    input  logic              dbl_i,
    output logic [DP_W-1:0]   res_o,
    output logic              pred_o,
    output logic [FLAG_W-1:0] flags_o
);
    typedef struct packed {
        logic [DP_W-1:0]   res;
        logic              pred;
        logic [FLAG_W-1:0] flags;
    } out_t;

    out_t out_d, out_q;

    logic             nan_a, nan_b, zero_a, zero_b, sign_a, sign_b;
    logic [MAG_W-1:0] mag_a, mag_b;
    logic             a_lt, a_eq, a_gt;
    logic [DP_W-1:0]  a_m, b_m, ones_m;
    fmm_op_e          op;

    fpmm_class #(.SP_EXP(SP_EXP), .SP_MAN(SP_MAN), .DP_EXP(DP_EXP), .DP_MAN(DP_MAN)) u_cls_a (
        .val_i(op_a_i), .dbl_i(dbl_i), .nan_o(nan_a), .zero_o(zero_a), .sign_o(sign_a), .mag_o(mag_a)
    );
    fpmm_class #(.SP_EXP(SP_EXP), .SP_MAN(SP_MAN), .DP_EXP(DP_EXP), .DP_MAN(DP_MAN)) u_cls_b (
        .val_i(op_b_i), .dbl_i(dbl_i), .nan_o(nan_b), .zero_o(zero_b), .sign_o(sign_b), .mag_o(mag_b)
    );
    fpmm_order #(.MAG_W(MAG_W)) u_ord (
        .sa_i(sign_a), .sb_i(sign_b), .za_i(zero_a), .zb_i(zero_b),
        .ma_i(mag_a), .mb_i(mag_b), .lt_o(a_lt), .eq_o(a_eq), .gt_o(a_gt)
    );

    assign op     = fmm_op_e'(op_i);
    assign a_m    = dbl_i ? op_a_i : {{(DP_W-SP_W){1'b0}}, op_a_i[SP_W-1:0]};
    assign b_m    = dbl_i ? op_b_i : {{(DP_W-SP_W){1'b0}}, op_b_i[SP_W-1:0]};
    assign ones_m = dbl_i ? {DP_W{1'b1}} : {{(DP_W-SP_W){1'b0}}, {SP_W{1'b1}}};

    always_comb begin
        out_d = '0;
        case (op)
            FMM_MIN, FMM_MAX: begin
                if (nan_a || nan_b) begin
                    out_d.flags[FLG_INVALID] = dbl_i;
                    if (nan_a && nan_b) out_d.res = ones_m;
                    else if (nan_a)     out_d.res = b_m;
                    else                out_d.res = a_m;
                end else if (op == FMM_MIN) begin
                    out_d.res = (a_lt || (a_eq && sign_a)) ? a_m : b_m;
                end else begin
                    out_d.res = (a_gt || (a_eq && !sign_a)) ? a_m : b_m;
                end
            end
            FMM_EQ: out_d.pred = !nan_a && !nan_b && a_eq;
            FMM_GT: out_d.pred = !nan_a && !nan_b && a_gt;
            FMM_GE: out_d.pred = !nan_a && !nan_b && (a_gt || a_eq);
            default: out_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign res_o   = out_q.res;
    assign pred_o  = out_q.pred;
    assign flags_o = out_q.flags;

    logic is_mm;
    assign is_mm = (op_i == 3'd0) || (op_i == 3'd1);

    // R3: a lone NaN in a is skipped
    assert_lone_nan_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_mm && nan_a && !nan_b) |=>
        res_o == ($past(dbl_i) ? $past(op_b_i) : {{(DP_W-SP_W){1'b0}}, $past(op_b_i[SP_W-1:0])}));

    // R5: two NaNs give all ones in the selected width
    assert_both_nan_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (is_mm && nan_a && nan_b) |=>
        res_o == ($past(dbl_i) ? {DP_W{1'b1}} : {{(DP_W-SP_W){1'b0}}, {SP_W{1'b1}}}));

    // R4, R6: single-precision work never flags
    assert_single_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbl_i) |=> flags_o == '0);

    // R9: compares with a NaN are false and quiet
    assert_cmp_nan_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i >= 3'd2 && op_i <= 3'd4 && (nan_a || nan_b)) |=> (!pred_o && flags_o == '0));

    // R10: no flag without a NaN operand
    assert_flag_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!nan_a && !nan_b) |=> flags_o == '0);
endmodule

// File: tb/sim_fpmm_unit.sv
module sim_fpmm_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] op_a, op_b, res;
    logic [2:0]  op;
    logic        dbl, pred;
    logic [7:0]  flags;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 0;

    always #2.5 clk = ~clk;

    fpmm_unit u0 (
        .clk(clk), .rst_n(rst_n), .op_a_i(op_a), .op_b_i(op_b), .op_i(op),
        .dbl_i(dbl), .res_o(res), .pred_o(pred), .flags_o(flags)
    );

    localparam logic [2:0] MIN = 3'd0, MAX = 3'd1, EQ = 3'd2, GT = 3'd3, GE = 3'd4;
    localparam logic [7:0] INV = 8'h02;
    localparam logic [31:0] S1 = 32'h3f800000, S2 = 32'h40000000, SM3 = 32'hc0400000,
                            SM1 = 32'hbf800000, SNAN = 32'h7fc00000, SNAN2 = 32'h7f800001,
                            SINF = 32'h7f800000, SNZ = 32'h80000000;
    localparam logic [63:0] D1 = 64'h3ff0000000000000, D2 = 64'h4000000000000000,
                            DM15 = 64'hbff8000000000000, DNAN = 64'h7ff8000000000000,
                            DINF = 64'h7ff0000000000000, DNZ = 64'h8000000000000000;

    task automatic apply(input logic [2:0] o, input logic d, input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        op = o; dbl = d; op_a = a; op_b = b;
        @(posedge clk);
        #1;
    endtask

    task automatic chk_res(input string tag, input logic [63:0] exp_r, input logic [7:0] exp_f);
        n_run++;
        if (res !== exp_r || flags !== exp_f) begin
            n_fail++;
            $display("FAIL %s: res=%h flags=%h expected res=%h flags=%h", tag, res, flags, exp_r, exp_f);
        end
    endtask

    task automatic chk_pred(input string tag, input logic exp_p);
        n_run++;
        if (pred !== exp_p || flags !== 8'h00 || res !== 64'h0) begin
            n_fail++;
            $display("FAIL %s: pred=%b flags=%h res=%h expected pred=%b flags=00 res=0", tag, pred, flags, res, exp_p);
        end
    endtask

    function automatic logic [63:0] sp(input logic [31:0] v);
        return {32'h0, v};
    endfunction

    function automatic logic [63:0] junk(input logic [31:0] v);
        return {32'hdeadbeef, v};
    endfunction

    task automatic t_reset();
        op = MIN; dbl = 1'b1; op_a = DNAN; op_b = D1;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        n_run++;
        if (res !== 64'h0 || pred !== 1'b0 || flags !== 8'h0) begin
            n_fail++;
            $display("FAIL R1: res=%h pred=%b flags=%h expected all zero", res, pred, flags);
        end
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_ordered();
        apply(MIN, 0, junk(S1), junk(S2));  chk_res("R2 sp min pos", sp(S1), 0);
        apply(MAX, 0, junk(S1), junk(S2));  chk_res("R2 sp max pos", sp(S2), 0);
        apply(MIN, 0, sp(SM3), sp(S1));     chk_res("R2 sp min mixed", sp(SM3), 0);
        apply(MAX, 0, sp(SM3), sp(SM1));    chk_res("R2 sp max negs", sp(SM1), 0);
        apply(MIN, 0, sp(SM3), sp(SM1));    chk_res("R2 sp min negs", sp(SM3), 0);
        apply(MAX, 0, sp(SINF), sp(S2));    chk_res("R2 sp max inf", sp(SINF), 0);
        apply(MIN, 1, D2, DM15);            chk_res("R2 dp min", DM15, 0);
        apply(MAX, 1, D1, D2);              chk_res("R2 dp max", D2, 0);
        apply(MAX, 1, DINF, D2);            chk_res("R2 dp max inf", DINF, 0);
    endtask

    task automatic t_one_nan();
        apply(MIN, 0, junk(SNAN), junk(S1)); chk_res("R3 R4 sp min nan a", sp(S1), 0);
        apply(MAX, 0, sp(S1), sp(SNAN));     chk_res("R3 R4 sp max nan b", sp(S1), 0);
        apply(MIN, 0, sp(SNAN2), sp(S2));    chk_res("R3 sp min low-bit nan", sp(S2), 0);
        apply(MIN, 1, DNAN, D1);             chk_res("R3 R4 dp min nan a", D1, INV);
        apply(MAX, 1, D2, DNAN);             chk_res("R3 R4 dp max nan b", D2, INV);
    endtask

    task automatic t_two_nan();
        apply(MIN, 0, junk(SNAN), junk(SNAN2)); chk_res("R5 R6 sp min two nan", 64'h00000000ffffffff, 0);
        apply(MAX, 0, sp(SNAN), sp(SNAN));      chk_res("R5 R6 sp max two nan", 64'h00000000ffffffff, 0);
        apply(MAX, 1, DNAN, DNAN);              chk_res("R5 R6 dp max two nan", 64'hffffffffffffffff, INV);
        apply(MIN, 1, DNAN, DNAN);              chk_res("R5 R6 dp min two nan", 64'hffffffffffffffff, INV);
    endtask

    task automatic t_zeros();
        apply(MIN, 0, sp(0), sp(SNZ)); chk_res("R7 sp min +0 -0", sp(SNZ), 0);
        apply(MAX, 0, sp(SNZ), sp(0)); chk_res("R7 sp max -0 +0", sp(0), 0);
        apply(MIN, 1, DNZ, 64'h0);     chk_res("R7 dp min -0 +0", DNZ, 0);
        apply(MAX, 1, 64'h0, DNZ);     chk_res("R7 dp max +0 -0", 64'h0, 0);
    endtask

    task automatic t_compare();
        apply(EQ, 0, sp(S1), sp(S1));    chk_pred("R8 eq same", 1);
        apply(EQ, 0, sp(0), sp(SNZ));    chk_pred("R8 eq signed zeros", 1);
        apply(EQ, 0, sp(S1), sp(S2));    chk_pred("R8 eq differ", 0);
        apply(GT, 0, sp(S2), sp(S1));    chk_pred("R8 gt true", 1);
        apply(GT, 0, sp(S1), sp(S2));    chk_pred("R8 gt false", 0);
        apply(GT, 0, sp(SM1), sp(SM3));  chk_pred("R8 gt negs", 1);
        apply(GE, 0, sp(S1), sp(S1));    chk_pred("R8 ge equal", 1);
        apply(GE, 1, DM15, D1);          chk_pred("R8 dp ge false", 0);
        apply(GT, 1, D2, DM15);          chk_pred("R8 dp gt true", 1);
    endtask

    task automatic t_compare_nan();
        apply(EQ, 0, sp(SNAN), sp(SNAN)); chk_pred("R9 sp eq nan", 0);
        apply(GE, 0, sp(S1), sp(SNAN));   chk_pred("R9 sp ge nan", 0);
        apply(GT, 1, DNAN, D1);           chk_pred("R9 dp gt nan", 0);
        apply(EQ, 1, DNAN, DNAN);         chk_pred("R9 dp eq nan", 0);
    endtask

    task automatic t_pulse_and_unused();
        apply(MIN, 1, DNAN, D1);        chk_res("R10 flagged op", D1, INV);
        apply(MIN, 1, D1, D2);          chk_res("R10 flag cleared", D1, 0);
        apply(3'd5, 1, DNAN, DNAN);     chk_res("R11 op5", 64'h0, 0);
        n_run++;
        if (pred !== 1'b0) begin n_fail++; $display("FAIL R11 op5 pred=%b expected 0", pred); end
        apply(3'd7, 1, D2, DNAN);       chk_res("R11 op7", 64'h0, 0);
    endtask

    initial begin
        t_reset();
        t_ordered();
        t_one_nan();
        t_two_nan();
        t_zeros();
        t_compare();
        t_compare_nan();
        t_pulse_and_unused();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule